// File: doc/BRIEF.md
# RV32I Integer Execute Stage

This block computes the value written back to the destination register for the integer arithmetic instruction classes of a 32-bit RISC-V core. The decoder supplies the major opcode, the funct3 and funct7 fields, the two source operand values, the sign-extended immediate and the program counter. The stage returns the write-back value and a flag that marks an opcode it handles.

It covers two groups of instructions. The register-register and register-immediate groups use one shared ALU: add and subtract, exclusive-or, or, and, signed and unsigned set-less-than, and left, logical-right and arithmetic-right shifts. The upper-immediate group covers loading an immediate directly and adding an immediate to the PC. The arithmetic is combinational and ends in one pipeline register, so each result appears one clock after its operands are presented. Fetch, register storage, immediate formation, memory access and branches belong to other stages.

Top module: `rv_exec`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.
- R2: Operands sampled at a rising clock edge produce `out_result`/`out_valid` at that edge. The outputs keep their value between edges.
- R3: Opcode 7'b0010011 (immediate form) uses `in_imm` as the second operand. funct3 selects the operation: 000 add, 100 xor, 110 or, 111 and. For funct3 000, funct7 bit 5 is ignored, so there is no immediate subtract.
- R4: Opcode 7'b0110011 (register form) uses `in_rs2` as the second operand. funct3 000 adds when funct7 bit 5 is 0 and computes rs1 minus rs2 when it is 1. funct3 100, 110 and 111 give xor, or and and.
- R5: funct3 010 compares rs1 and the second operand as two's-complement values and writes 1 when rs1 is smaller, otherwise 0.
- R6: funct3 011 makes the same comparison on unsigned values and writes 1 or 0.
- R7: Shifts (funct3 001 and 101) use only bits [4:0] of the second operand as the shift amount. Higher bits have no effect.
- R8: funct3 001 shifts left and fills with zeros. funct3 101 shifts right: it fills with zeros when funct7 bit 5 is 0 and with copies of rs1 bit 31 when it is 1. This holds in both forms.
- R9: Opcode 7'b0110111 returns `in_imm` unchanged.
- R10: Opcode 7'b0010111 returns `in_pc + in_imm`, modulo 2^32.
- R11: Any other opcode gives `out_valid` = 0 and `out_result` = 0. The four opcodes above give `out_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_opcode | input | 7 | Major opcode of the decoded instruction |
| in_funct3 | input | 3 | Operation selector |
| in_funct7 | input | 7 | Variant field; only bit 5 is used |
| in_rs1 | input | 32 | First source operand value |
| in_rs2 | input | 32 | Second source register value |
| in_imm | input | 32 | Sign-extended immediate |
| in_pc | input | 32 | Address of the instruction |
| out_result | output | 32 | Value for the destination register |
| out_valid | output | 1 | Opcode belongs to a handled class |

## Verification
The bound checker watches several properties on every clock. An unhandled opcode must leave a zero result. The valid flag must follow the previous cycle's opcode class. The upper-immediate results and the subtract path must match the operands of the cycle before. Any comparison result must carry at most one bit. The bench's scenarios are needed for the rest. They cover the shift amount being masked to five bits and sign fill against zero fill. They also cover signed and unsigned order on operands where the two disagree, funct7 being ignored for the immediate add, and the output holding steady between clock edges.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;

    localparam int DATA_W = 32;

    localparam logic [6:0] OPC_ALU_IMM = 7'b0010011;
    localparam logic [6:0] OPC_ALU_REG = 7'b0110011;
    localparam logic [6:0] OPC_LUI     = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC   = 7'b0010111;

    typedef enum logic [2:0] {
        F3_ADD  = 3'b000,
        F3_SLL  = 3'b001,
        F3_SLT  = 3'b010,
        F3_SLTU = 3'b011,
        F3_XOR  = 3'b100,
        F3_SR   = 3'b101,
        F3_OR   = 3'b110,
        F3_AND  = 3'b111
    } f3_e;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_IMM   = 3'd1,
        CLS_REG   = 3'd2,
        CLS_LUI   = 3'd3,
        CLS_AUIPC = 3'd4
    } cls_e;

endpackage

// File: rtl/rv_exec_opsel.sv
module rv_exec_opsel
    import rv_exec_pkg::*;
#(
    parameter int XLEN    = DATA_W,
    parameter int SHAMT_W = $clog2(XLEN)
) (
    input  logic [6:0]         opcode,
    input  logic [2:0]         funct3,
    input  logic               alt_bit,
    input  logic [XLEN-1:0]    rs2,
    input  logic [XLEN-1:0]    imm,
    output cls_e               cls,
    output logic [XLEN-1:0]    opb,
    output logic [SHAMT_W-1:0] shamt,
    output logic               sub_sel,
    output logic               arith_sel
);

    always_comb begin
        unique case (opcode)
            OPC_ALU_IMM: cls = CLS_IMM;
            OPC_ALU_REG: cls = CLS_REG;
            OPC_LUI:     cls = CLS_LUI;
            OPC_AUIPC:   cls = CLS_AUIPC;
            default:     cls = CLS_NONE;
        endcase
    end

    always_comb begin
        opb       = (cls == CLS_REG) ? rs2 : imm;
        shamt     = opb[SHAMT_W-1:0];
        sub_sel   = (cls == CLS_REG) && (f3_e'(funct3) == F3_ADD) && alt_bit;
        arith_sel = (f3_e'(funct3) == F3_SR) && alt_bit;
    end

endmodule

// File: rtl/rv_exec_shift.sv
module rv_exec_shift
    import rv_exec_pkg::*;
#(
    parameter int XLEN    = DATA_W,
    parameter int SHAMT_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]    data,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               left,
    input  logic               arith,
    output logic [XLEN-1:0]    result
);

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] stg [0:SHAMT_W];
    logic            fill;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            src[i] = left ? data[XLEN-1-i] : data[i];
        end
    end

    assign fill   = arith & ~left & data[XLEN-1];
    assign stg[0] = src;

    for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stg[g+1] = shamt[g] ? {{STEP{fill}}, stg[g][XLEN-1:STEP]} : stg[g];
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            result[i] = left ? stg[SHAMT_W][XLEN-1-i] : stg[SHAMT_W][i];
        end
    end

endmodule

// File: rtl/rv_exec_alu.sv
module rv_exec_alu
    import rv_exec_pkg::*;
#(
    parameter int XLEN    = DATA_W,
    parameter int SHAMT_W = $clog2(XLEN)
) (
    input  cls_e               cls,
    input  logic [2:0]         funct3,
    input  logic [XLEN-1:0]    opa,
    input  logic [XLEN-1:0]    opb,
    input  logic [XLEN-1:0]    pc,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sub_sel,
    input  logic               arith_sel,
    output logic [XLEN-1:0]    result,
    output logic               valid
);

    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] shifted;
    logic            lt_s;
    logic            lt_u;
    logic            shl;

    assign sum  = sub_sel ? (opa - opb) : (opa + opb);
    assign lt_s = $signed(opa) < $signed(opb);
    assign lt_u = opa < opb;
    assign shl  = (f3_e'(funct3) == F3_SLL);

    rv_exec_shift #(
        .XLEN    (XLEN),
        .SHAMT_W (SHAMT_W)
    ) i_shift (
        .data   (opa),
        .shamt  (shamt),
        .left   (shl),
        .arith  (arith_sel),
        .result (shifted)
    );

    always_comb begin
        result = '0;
        valid  = 1'b1;
        unique case (cls)
            CLS_IMM, CLS_REG: begin
                unique case (f3_e'(funct3))
                    F3_ADD:  result = sum;
                    F3_SLL:  result = shifted;
                    F3_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
                    F3_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
                    F3_XOR:  result = opa ^ opb;
                    F3_SR:   result = shifted;
                    F3_OR:   result = opa | opb;
                    F3_AND:  result = opa & opb;
                    default: result = '0;
                endcase
            end
            CLS_LUI:   result = opb;
            CLS_AUIPC: result = pc + opb;
            default: begin
                result = '0;
                valid  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rv_exec.sv
module rv_exec
    import rv_exec_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      in_opcode,
    input  logic [2:0]      in_funct3,
    input  logic [6:0]      in_funct7,
    input  logic [XLEN-1:0] in_rs1,
    input  logic [XLEN-1:0] in_rs2,
    input  logic [XLEN-1:0] in_imm,
    input  logic [XLEN-1:0] in_pc,
    output logic [XLEN-1:0] out_result,
    output logic            out_valid
);

    localparam int SHAMT_W = $clog2(XLEN);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
    } exec_st_t;

    cls_e               cls;
    logic [XLEN-1:0]    opb;
    logic [SHAMT_W-1:0] shamt;
    logic               sub_sel;
    logic               arith_sel;
    logic [XLEN-1:0]    alu_res;
    logic               alu_valid;
    logic               unused_funct7_bits;

    exec_st_t st_d;
    exec_st_t st_q;

    assign unused_funct7_bits = ^{in_funct7[6], in_funct7[4:0]};

    rv_exec_opsel #(
        .XLEN    (XLEN),
        .SHAMT_W (SHAMT_W)
    ) i_opsel (
        .opcode    (in_opcode),
        .funct3    (in_funct3),
        .alt_bit   (in_funct7[5]),
        .rs2       (in_rs2),
        .imm       (in_imm),
        .cls       (cls),
        .opb       (opb),
        .shamt     (shamt),
        .sub_sel   (sub_sel),
        .arith_sel (arith_sel)
    );

    rv_exec_alu #(
        .XLEN    (XLEN),
        .SHAMT_W (SHAMT_W)
    ) i_alu (
        .cls       (cls),
        .funct3    (in_funct3),
        .opa       (in_rs1),
        .opb       (opb),
        .pc        (in_pc),
        .shamt     (shamt),
        .sub_sel   (sub_sel),
        .arith_sel (arith_sel),
        .result    (alu_res),
        .valid     (alu_valid)
    );

    always_comb begin
        st_d.valid  = alu_valid;
        st_d.result = alu_valid ? alu_res : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_result = st_q.result;
    assign out_valid  = st_q.valid;

endmodule

// File: rtl/rv_exec_chk.sv
module rv_exec_chk
    import rv_exec_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [6:0]      in_opcode,
    input logic [2:0]      in_funct3,
    input logic [6:0]      in_funct7,
    input logic [XLEN-1:0] in_rs1,
    input logic [XLEN-1:0] in_rs2,
    input logic [XLEN-1:0] in_imm,
    input logic [XLEN-1:0] in_pc,
    input logic [XLEN-1:0] out_result,
    input logic            out_valid
);

    logic handled;
    logic alu_cls;
    assign handled = (in_opcode == OPC_ALU_IMM) || (in_opcode == OPC_ALU_REG) ||
                     (in_opcode == OPC_LUI) || (in_opcode == OPC_AUIPC);
    assign alu_cls = (in_opcode == OPC_ALU_IMM) || (in_opcode == OPC_ALU_REG);

    // R11: an unhandled class never leaks a value
    p_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0));

    // R2, R11: the flag follows the opcode class of the previous cycle
    p_valid_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(handled)));

    // R9
    p_lui_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_opcode == OPC_LUI) |=> (out_result == $past(in_imm)));

    // R10
    p_auipc_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_opcode == OPC_AUIPC) |=> (out_result == $past(in_pc) + $past(in_imm)));

    // R4
    p_sub_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_opcode == OPC_ALU_REG) && (in_funct3 == 3'b000) && in_funct7[5])
        |=> (out_result == $past(in_rs1) - $past(in_rs2)));

    // R5, R6: a comparison yields a single bit
    p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_cls && (in_funct3[2:1] == 2'b01)) |=> (out_result[XLEN-1:1] == '0));

endmodule

bind rv_exec rv_exec_chk #(.XLEN(XLEN)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_opcode  (in_opcode),
    .in_funct3  (in_funct3),
    .in_funct7  (in_funct7),
    .in_rs1     (in_rs1),
    .in_rs2     (in_rs2),
    .in_imm     (in_imm),
    .in_pc      (in_pc),
    .out_result (out_result),
    .out_valid  (out_valid)
);

// File: tb/test_rv_exec.sv
module test_rv_exec;

    localparam logic [6:0] OI = 7'b0010011;
    localparam logic [6:0] OR = 7'b0110011;
    localparam logic [6:0] OL = 7'b0110111;
    localparam logic [6:0] OA = 7'b0010111;

    typedef struct packed {
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [6:0]  f7;
        logic [31:0] rs1;
        logic [31:0] rs2;
        logic [31:0] imm;
        logic [31:0] pc;
        logic [31:0] exp;
        logic        expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{OI, 3'b000, 7'h20, 32'h5,        32'h0,        32'hFFFFFFFD, 32'h0, 32'h2,        1'b1, 4'd3},  // R3 addi, funct7 ignored
        '{OI, 3'b100, 7'h00, 32'hF0F0F0F0, 32'h0,        32'hFFFFFFFF, 32'h0, 32'h0F0F0F0F, 1'b1, 4'd3},  // R3
        '{OI, 3'b110, 7'h00, 32'h00000F00, 32'h0,        32'h000000FF, 32'h0, 32'h00000FFF, 1'b1, 4'd3},  // R3
        '{OI, 3'b111, 7'h00, 32'h12345678, 32'h0,        32'h0000FF00, 32'h0, 32'h00005600, 1'b1, 4'd3},  // R3
        '{OR, 3'b000, 7'h00, 32'hFFFFFFFF, 32'h1,        32'h7,        32'h0, 32'h0,        1'b1, 4'd4},  // R4 add wraps
        '{OR, 3'b000, 7'h20, 32'h3,        32'h5,        32'h7,        32'h0, 32'hFFFFFFFE, 1'b1, 4'd4},  // R4 sub
        '{OR, 3'b100, 7'h00, 32'hAAAA5555, 32'hFFFF0000, 32'h0,        32'h0, 32'h55555555, 1'b1, 4'd4},  // R4
        '{OR, 3'b110, 7'h00, 32'h0000000F, 32'h000000F0, 32'h0,        32'h0, 32'h000000FF, 1'b1, 4'd4},  // R4
        '{OR, 3'b111, 7'h00, 32'hFF00FF00, 32'h0FF00FF0, 32'h0,        32'h0, 32'h0F000F00, 1'b1, 4'd4},  // R4
        '{OR, 3'b010, 7'h00, 32'hFFFFFFFF, 32'h1,        32'h0,        32'h0, 32'h1,        1'b1, 4'd5},  // R5
        '{OR, 3'b011, 7'h00, 32'hFFFFFFFF, 32'h1,        32'h0,        32'h0, 32'h0,        1'b1, 4'd6},  // R6
        '{OI, 3'b010, 7'h00, 32'h5,        32'h0,        32'hFFFFFFFF, 32'h0, 32'h0,        1'b1, 4'd5},  // R5
        '{OI, 3'b011, 7'h00, 32'h5,        32'h0,        32'hFFFFFFFF, 32'h0, 32'h1,        1'b1, 4'd6},  // R6
        '{OR, 3'b010, 7'h00, 32'h7,        32'h7,        32'h0,        32'h0, 32'h0,        1'b1, 4'd5},  // R5 equal
        '{OR, 3'b001, 7'h00, 32'h1,        32'h24,       32'h0,        32'h0, 32'h10,       1'b1, 4'd7},  // R7
        '{OI, 3'b001, 7'h00, 32'h80000001, 32'h0,        32'h1,        32'h0, 32'h2,        1'b1, 4'd8},  // R8
        '{OR, 3'b101, 7'h00, 32'h80000000, 32'h1F,       32'h0,        32'h0, 32'h1,        1'b1, 4'd8},  // R8
        '{OR, 3'b101, 7'h20, 32'h80000000, 32'h4,        32'h0,        32'h0, 32'hF8000000, 1'b1, 4'd8},  // R8
        '{OI, 3'b101, 7'h20, 32'h80000000, 32'h0,        32'h0000043F, 32'h0, 32'hFFFFFFFF, 1'b1, 4'd7},  // R7
        '{OI, 3'b101, 7'h00, 32'hF0000000, 32'h0,        32'h24,       32'h0, 32'h0F000000, 1'b1, 4'd7},  // R7
        '{OR, 3'b101, 7'h20, 32'h40000000, 32'h21,       32'h0,        32'h0, 32'h20000000, 1'b1, 4'd8},  // R8
        '{OL, 3'b000, 7'h00, 32'h1234,     32'h0,        32'hABCDE000, 32'h0, 32'hABCDE000, 1'b1, 4'd9},  // R9
        '{OA, 3'b000, 7'h00, 32'h0,        32'h0,        32'hFFFFF000, 32'h00001000, 32'h0, 1'b1, 4'd10}, // R10
        '{OA, 3'b000, 7'h00, 32'h0,        32'h0,        32'h00010000, 32'h80000000, 32'h80010000, 1'b1, 4'd10}, // R10
        '{7'b0000011, 3'b000, 7'h00, 32'h5, 32'h6,       32'h7,        32'h0, 32'h0,        1'b0, 4'd11}  // R11
    };

    logic        clk;
    logic        rst_n;
    logic [6:0]  in_opcode;
    logic [2:0]  in_funct3;
    logic [6:0]  in_funct7;
    logic [31:0] in_rs1;
    logic [31:0] in_rs2;
    logic [31:0] in_imm;
    logic [31:0] in_pc;
    logic [31:0] out_result;
    logic        out_valid;

    int checks;
    int failures;

    rv_exec i_rv_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_opcode  (in_opcode),
        .in_funct3  (in_funct3),
        .in_funct7  (in_funct7),
        .in_rs1     (in_rs1),
        .in_rs2     (in_rs2),
        .in_imm     (in_imm),
        .in_pc      (in_pc),
        .out_result (out_result),
        .out_valid  (out_valid)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act_r, input logic act_v,
                         input logic [31:0] exp_r, input logic exp_v);
        checks++;
        if (act_r !== exp_r || act_v !== exp_v) begin
            failures++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     req, act_r, act_v, exp_r, exp_v);
        end
    endtask

    task automatic drive(input vec_t v);
        in_opcode = v.opc;
        in_funct3 = v.f3;
        in_funct7 = v.f7;
        in_rs1    = v.rs1;
        in_rs2    = v.rs2;
        in_imm    = v.imm;
        in_pc     = v.pc;
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks    = 0;
        failures  = 0;
        rst_n     = 1'b0;
        drive(VEC[0]);
        repeat (2) @(negedge clk);
        check("R1 reset", out_result, out_valid, 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  out_result, out_valid, VEC[i].exp, VEC[i].expv);
        end

        // R11: branch opcode is not handled
        @(negedge clk);
        drive('{7'b1100011, 3'b000, 7'h00, 32'h1, 32'h1, 32'h8, 32'h0, 32'h0, 1'b0, 4'd11});
        @(negedge clk);
        check("R11 branch opcode", out_result, out_valid, 32'h0, 1'b0);

        // R2: output holds until the next rising edge
        @(negedge clk);
        drive(VEC[21]);
        @(negedge clk);
        drive(VEC[6]);
        #2;
        check("R2 hold before edge", out_result, out_valid, 32'hABCDE000, 1'b1);
        @(negedge clk);
        check("R2 update after edge", out_result, out_valid, 32'h55555555, 1'b1);

        // R1: reset in the middle of operation clears the outputs
        #1 rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", out_result, out_valid, 32'h0, 1'b0);
        @(negedge clk);
        check("R1 held in reset", out_result, out_valid, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 after reset release", out_result, out_valid, 32'h55555555, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule